// File: doc/BRIEF.md
# Saturating Up/Down Wiper Controller

This block is the digital half of a tap-select potentiometer. Three control lines drive it: an active-low select, an increment strobe and a direction level. While the block is selected, each falling edge of the strobe moves a position count one step up or down. The count stays at its end points instead of wrapping. The count is decoded into a one-hot vector that closes exactly one of the tap switches.

The block also models a nonvolatile slot that holds a saved position. Taking select high while the strobe is high starts a timed store of the live count. While the store runs the block reports busy, and when the store finishes the saved value is updated. Taking select high while the strobe is low leaves the saved value untouched. The live position stays where it is until it is moved again or the block is reset. Reset stands for a power cycle: it reloads the live count from the saved slot. The slot holds a parameter value from power-on until the first store completes. All three control lines are brought into the clock domain through two-flop synchronisers, and edges are detected after synchronisation.

Top module: `tap_step_ctrl`

## Requirements
- R1: During and after reset, `pos` equals the saved value and `busy` is low. The saved value is NV_INIT (default 50) until the first store completes.
- R2: While `sel_n` is low, a falling edge on `step_n` with `dir_up` high raises `pos` by one. With `dir_up` low, the same edge lowers `pos` by one.
- R3: `pos` never leaves 0..NUM_TAPS-1 (default 0..99). An up step at the top value and a down step at 0 leave it unchanged.
- R4: Strobe edges while `sel_n` is high leave `pos` unchanged.
- R5: `dir_up` may change between strobes within one selection, and each strobe follows the level `dir_up` has at that strobe.
- R6: A rising edge of `sel_n` while `step_n` is high raises `busy` for STORE_CYCLES clocks. At the end of that time the count captured at the deselect becomes the saved value, and the next reset recalls it.
- R7: A rising edge of `sel_n` while `step_n` is low starts no store: `busy` stays low, `pos` is kept, and the saved value is unchanged.
- R8: Strobe edges that arrive while `busy` is high leave `pos` unchanged, even when the block is selected.
- R9: `tap_sel` has exactly one bit set, and that bit is the bit at index `pos`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power cycle), recalls the saved position |
| sel_n | input | 1 | Active-low select, asynchronous to clk |
| step_n | input | 1 | Increment strobe, acts on its falling edge, asynchronous to clk |
| dir_up | input | 1 | Step direction: 1 = up, 0 = down |
| busy | output | 1 | High while a store is in progress |
| pos | output | 7 | Live position count |
| tap_sel | output | 100 | One-hot tap select |

## Verification
The embedded assertions check on every cycle that the count stays in range and never moves by more than one step per clock. They also check that the count is frozen while a store is busy, that the tap vector is one-hot and matches the count, and that a store starts only on a deselect with the strobe high. Other behaviour spans a reset and can only be shown by the bench's scenarios: that a completed store changes what the next reset recalls, and that a deselect with the strobe low leaves the saved value alone. The bench scenarios also show that the direction is honoured strobe by strobe and that both end points saturate.

// File: rtl/tapctl_pkg.sv
package tapctl_pkg;

    // Default geometry and timing
    localparam int unsigned DEF_NUM_TAPS     = 100;
    localparam int unsigned DEF_STORE_CYCLES = 40;
    localparam int unsigned DEF_NV_INIT      = 50;

    // Bit positions inside the synchronised control bundle
    localparam int unsigned CTL_SEL  = 0;
    localparam int unsigned CTL_STEP = 1;
    localparam int unsigned CTL_DIR  = 2;
    localparam int unsigned CTL_W    = 3;

    // Idle (power-on) levels of the raw control lines: deselected, strobe high
    localparam logic [CTL_W-1:0] CTL_IDLE = 3'b011;

    // Decoded control events, one clock after synchronisation
    typedef struct packed {
        logic sel_low;    // selected level
        logic sel_rise;   // deselect edge
        logic step_fall;  // active strobe edge
        logic step_high;  // strobe level
        logic dir_up;     // direction level
    } ctl_evt_t;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_WRITE = 1'b1
    } store_state_e;

    function automatic ctl_evt_t decode_evt(input logic [CTL_W-1:0] cur,
                                            input logic [CTL_W-1:0] prv);
        ctl_evt_t e;
        e.sel_low   = ~cur[CTL_SEL];
        e.sel_rise  =  cur[CTL_SEL]  & ~prv[CTL_SEL];
        e.step_fall = ~cur[CTL_STEP] &  prv[CTL_STEP];
        e.step_high =  cur[CTL_STEP];
        e.dir_up    =  cur[CTL_DIR];
        return e;
    endfunction

endpackage

// File: rtl/tapctl_sync.sv
module tapctl_sync #(
    parameter int unsigned W       = 3,
    parameter int unsigned STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic [W-1:0] dprev
);
    genvar b;
    generate
        for (b = 0; b < W; b++) begin : g_bit
            logic [STAGES-1:0] chain_q;
            logic              prev_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain_q <= {STAGES{RST_VAL[b]}};
                    prev_q  <= RST_VAL[b];
                end else begin
                    chain_q <= {chain_q[STAGES-2:0], din[b]};
                    prev_q  <= chain_q[STAGES-1];
                end
            end
            assign dout[b]  = chain_q[STAGES-1];
            assign dprev[b] = prev_q;
        end
    endgenerate
endmodule

// File: rtl/tapctl_counter.sv
module tapctl_counter #(
    parameter int unsigned NUM_TAPS = 100,
    localparam int unsigned POS_W   = $clog2(NUM_TAPS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [POS_W-1:0] load_val,
    input  logic             step_en,
    input  logic             up,
    output logic [POS_W-1:0] pos
);
    localparam logic [POS_W-1:0] LAST = POS_W'(NUM_TAPS - 1);

    logic [POS_W-1:0] pos_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= load_val;
        end else if (step_en) begin
            if (up) begin
                if (pos_q != LAST) pos_q <= pos_q + 1'b1;
            end else begin
                if (pos_q != '0) pos_q <= pos_q - 1'b1;
            end
        end
    end

    assign pos = pos_q;

    // R3
    pos_range_chk: assert property (@(posedge clk) disable iff (rst)
        pos_q <= LAST);

    // R2
    single_step_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (pos_q == $past(pos_q) ||
                         pos_q == $past(pos_q) + 1'b1 ||
                         pos_q == $past(pos_q) - 1'b1));
endmodule

// File: rtl/tapctl_store.sv
module tapctl_store
    import tapctl_pkg::*;
#(
    parameter int unsigned POS_W        = 7,
    parameter int unsigned STORE_CYCLES = 40,
    parameter int unsigned NV_INIT      = 50,
    localparam int unsigned TMR_W       = $clog2(STORE_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [POS_W-1:0] cur_pos,
    output logic             busy,
    output logic [POS_W-1:0] saved
);
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(STORE_CYCLES - 1);

    store_state_e     state_q;
    logic [TMR_W-1:0] tmr_q;
    logic [POS_W-1:0] pend_q;
    logic [POS_W-1:0] nv_q;
    logic             commit;

    assign commit = (state_q == ST_WRITE) && (tmr_q == TMR_LAST) && !rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            tmr_q   <= '0;
            pend_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_WRITE;
                        tmr_q   <= '0;
                        pend_q  <= cur_pos;
                    end
                end
                ST_WRITE: begin
                    if (tmr_q == TMR_LAST) state_q <= ST_IDLE;
                    else                   tmr_q   <= tmr_q + 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Nonvolatile slot: no reset, power-on content is NV_INIT
    initial nv_q = POS_W'(NV_INIT);
    always @(posedge clk) begin
        if (commit) nv_q <= pend_q;
    end

    assign busy  = (state_q == ST_WRITE);
    assign saved = nv_q;

    // R6
    store_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    // R6
    store_timer_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> tmr_q <= TMR_LAST);
endmodule

// File: rtl/tapctl_decode.sv
module tapctl_decode #(
    parameter int unsigned NUM_TAPS = 100,
    localparam int unsigned POS_W   = $clog2(NUM_TAPS)
) (
    input  logic [POS_W-1:0]    pos,
    output logic [NUM_TAPS-1:0] taps
);
    genvar t;
    generate
        for (t = 0; t < NUM_TAPS; t++) begin : g_tap
            assign taps[t] = (pos == POS_W'(t));
        end
    endgenerate
endmodule

// File: rtl/tap_step_ctrl.sv
module tap_step_ctrl
    import tapctl_pkg::*;
#(
    parameter int unsigned NUM_TAPS     = DEF_NUM_TAPS,
    parameter int unsigned STORE_CYCLES = DEF_STORE_CYCLES,
    parameter int unsigned NV_INIT      = DEF_NV_INIT,
    localparam int unsigned POS_W       = $clog2(NUM_TAPS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sel_n,
    input  logic                step_n,
    input  logic                dir_up,
    output logic                busy,
    output logic [POS_W-1:0]    pos,
    output logic [NUM_TAPS-1:0] tap_sel
);
    logic [CTL_W-1:0] raw_ctl;
    logic [CTL_W-1:0] cur_ctl;
    logic [CTL_W-1:0] prv_ctl;
    ctl_evt_t         evt;
    logic             step_en;
    logic             store_go;
    logic [POS_W-1:0] saved;

    always_comb begin
        raw_ctl           = '0;
        raw_ctl[CTL_SEL]  = sel_n;
        raw_ctl[CTL_STEP] = step_n;
        raw_ctl[CTL_DIR]  = dir_up;
    end

    tapctl_sync #(
        .W(CTL_W), .STAGES(2), .RST_VAL(CTL_IDLE)
    ) u_sync (
        .clk(clk), .rst(rst), .din(raw_ctl), .dout(cur_ctl), .dprev(prv_ctl)
    );

    assign evt      = decode_evt(cur_ctl, prv_ctl);
    assign step_en  = evt.step_fall & evt.sel_low & ~busy;
    assign store_go = evt.sel_rise & evt.step_high & ~busy;

    tapctl_counter #(.NUM_TAPS(NUM_TAPS)) u_cnt (
        .clk(clk), .rst(rst), .load_val(saved),
        .step_en(step_en), .up(evt.dir_up), .pos(pos)
    );

    tapctl_store #(
        .POS_W(POS_W), .STORE_CYCLES(STORE_CYCLES), .NV_INIT(NV_INIT)
    ) u_store (
        .clk(clk), .rst(rst), .start(store_go), .cur_pos(pos),
        .busy(busy), .saved(saved)
    );

    tapctl_decode #(.NUM_TAPS(NUM_TAPS)) u_dec (
        .pos(pos), .taps(tap_sel)
    );

    // R8
    busy_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(pos));

    // R9
    tap_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(tap_sel) == 1 && tap_sel[pos]);

    // R7
    no_store_chk: assert property (@(posedge clk) disable iff (rst)
        (evt.sel_rise && !evt.step_high && !busy) |=> !busy);

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!evt.sel_low && !$past(rst)) |=> $stable(pos));
endmodule

// File: tb/tap_step_ctrl_tb_top.sv
module tap_step_ctrl_tb_top;
    localparam int NT = 100;
    localparam int SC = 40;
    localparam int NI = 50;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sel_n = 1'b1;
    logic          step_n = 1'b1;
    logic          dir_up = 1'b0;
    logic          busy;
    logic [6:0]    pos;
    logic [NT-1:0] tap_sel;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    typedef struct {
        string tag;
        int    exp_pos;
        bit    exp_busy;
    } exp_item_t;

    exp_item_t sb_q[$];

    always #2 clk = ~clk;

    tap_step_ctrl #(.NUM_TAPS(NT), .STORE_CYCLES(SC), .NV_INIT(NI)) dut_i (
        .clk(clk), .rst(rst), .sel_n(sel_n), .step_n(step_n),
        .dir_up(dir_up), .busy(busy), .pos(pos), .tap_sel(tap_sel)
    );

    // Monitor: pops expectations and compares at the falling edge
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            exp_item_t it;
            logic [NT-1:0] ev;
            it = sb_q.pop_front();
            ev = '0;
            ev[it.exp_pos] = 1'b1;
            n_checks++;
            if (int'(pos) != it.exp_pos || busy != it.exp_busy) begin
                n_fails++;
                $display("FAIL %s: pos=%0d busy=%0b expected pos=%0d busy=%0b",
                         it.tag, pos, busy, it.exp_pos, it.exp_busy);
            end
            n_checks++;
            if (tap_sel != ev) begin
                n_fails++;
                $display("FAIL R9 (%s): tap_sel=%h expected %h", it.tag, tap_sel, ev);
            end
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_now(input string tag, input int p, input bit b);
        exp_item_t it;
        @(posedge clk);
        #1;
        it.tag = tag; it.exp_pos = p; it.exp_busy = b;
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    task automatic strobe(input bit up);
        dir_up = up;
        wait_cyc(2);
        step_n = 1'b0;
        wait_cyc(4);
        step_n = 1'b1;
        wait_cyc(4);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        wait_cyc(3);
        rst = 1'b0;
        wait_cyc(1);
    endtask

    initial begin
        int model;
        wait_cyc(3);
        rst = 1'b0;
        wait_cyc(1);
        // R1: reset state
        expect_now("R1 power-on recall", NI, 1'b0);

        // R2: up and down steps
        sel_n = 1'b0; wait_cyc(4);
        strobe(1'b1); strobe(1'b1); strobe(1'b1);
        expect_now("R2 three up steps", NI + 3, 1'b0);
        // R5: direction change within one selection
        strobe(1'b0);
        expect_now("R5 direction reversed", NI + 2, 1'b0);
        strobe(1'b1); strobe(1'b0); strobe(1'b0);
        expect_now("R5 mixed directions", NI + 1, 1'b0);

        // R6: deselect with strobe high starts a store
        sel_n = 1'b1; wait_cyc(4);
        expect_now("R6 store busy", NI + 1, 1'b1);
        // R8: selected strobes during the store are ignored
        sel_n = 1'b0; wait_cyc(4);
        strobe(1'b1); strobe(1'b1);
        expect_now("R8 strobes ignored while busy", NI + 1, 1'b1);
        wait_cyc(SC + 5);
        expect_now("R6 store finished", NI + 1, 1'b0);

        // R7: deselect with strobe low, no store
        strobe(1'b1);
        dir_up = 1'b1; wait_cyc(2);
        step_n = 1'b0; wait_cyc(4);  // this edge is a step
        sel_n = 1'b1; wait_cyc(4);
        step_n = 1'b1; wait_cyc(4);
        expect_now("R7 no store, position kept", NI + 3, 1'b0);
        wait_cyc(SC + 5);
        expect_now("R7 busy never raised", NI + 3, 1'b0);

        // R6/R7: reset recalls the value stored earlier
        do_reset();
        expect_now("R6 recall after store", NI + 1, 1'b0);

        // R4: strobes while deselected
        strobe(1'b1); strobe(1'b0); strobe(1'b1);
        expect_now("R4 deselected strobes ignored", NI + 1, 1'b0);

        // R3: saturation at top and bottom
        sel_n = 1'b0; wait_cyc(4);
        model = NI + 1;
        for (int i = 0; i < 55; i++) begin
            strobe(1'b1);
            if (model < NT - 1) model++;
        end
        expect_now("R3 saturate at top", model, 1'b0);
        strobe(1'b1);
        expect_now("R3 up at top holds", NT - 1, 1'b0);
        strobe(1'b0);
        expect_now("R2 down from top", NT - 2, 1'b0);
        for (int i = 0; i < 105; i++) strobe(1'b0);
        expect_now("R3 saturate at bottom", 0, 1'b0);
        strobe(1'b0);
        expect_now("R3 down at zero holds", 0, 1'b0);

        // R6: store zero and recall it
        sel_n = 1'b1; wait_cyc(4);
        expect_now("R6 store of zero busy", 0, 1'b1);
        wait_cyc(SC + 5);
        sel_n = 1'b0; wait_cyc(4);
        strobe(1'b1); strobe(1'b1);
        expect_now("R2 moved after store", 2, 1'b0);
        dir_up = 1'b0;
        do_reset();
        expect_now("R1 recall of stored zero", 0, 1'b0);

        wait_cyc(4);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule